// File: doc/BRIEF.md
# Endpoint Status and Interrupt Register

This block holds the status word and the interrupt flags of one endpoint in a USB device controller. It follows the endpoint's halt state. The halt state is raised by a set-feature request that selects endpoint halt, or by a STALL handshake. It is lowered only by the matching clear-feature request. The block also mirrors the endpoint's direction and whether the endpoint is present in the active configuration.

The packet engine reports each successful packet with its byte count. From that count the block raises end-of-packet. It raises end-of-transfer when a transfer finishes, meaning a short packet, or a zero-length packet that directly follows a full-size one. Each interrupt flag is sticky until the CPU clears it by writing a one. A separate enable register gates the flags onto a single interrupt line. While end-of-transfer is pending on an OUT endpoint, the block asks the protocol engine to NAK every OUT packet.

Top module: `ep_stat_reg`

## Requirements
- R1: After reset the status word, the enable word, `irq` and `out_nak` are all zero.
- R2: At address 0 the status word carries halt status in bit 15, direction in bit 14 and present in bit 13. Direction and present are the `cfg_dir_in` and `cfg_present` inputs registered once. Bits 15..13 ignore CPU writes. Bits 12..5 and bit 0 read as zero.
- R3: The halt status sets one cycle after `req_set_halt` or `stall_sent`. When a set and `req_clr_halt` arrive in the same cycle, the set wins.
- R4: The halt status clears one cycle after `req_clr_halt`, and nothing else clears it.
- R5: The halt-event flag (status bit 1) sets on the edge where halt goes from 0 to 1. The unhalt flag (bit 2) sets on the edge where halt goes from 1 to 0.
- R6: The end-of-packet flag (bit 3) sets one cycle after each `pkt_done`.
- R7: The end-of-transfer flag (bit 4) sets one cycle after a `pkt_done` in either of two cases. The first is a length that is non-zero and below `max_pkt`. The second is a zero length when the previous packet had a length of at least `max_pkt`. A zero-length packet in any other case sets only end-of-packet.
- R8: A write to address 0 clears each flag in bits 4..1 whose data bit is 1. A data bit of 0 leaves its flag unchanged. A hardware set in the same cycle as a clear wins.
- R9: Address 1 holds the enable word in bits 4..1, and its other bits read as zero. `irq` is high when any flag and its enable bit are both set.
- R10: `out_nak` is high when the endpoint is OUT (registered direction 0) and end-of-transfer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_present | input | 1 | Endpoint exists in the active configuration |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| req_set_halt | input | 1 | Pulse: decoded set-feature with endpoint-halt selector |
| req_clr_halt | input | 1 | Pulse: decoded clear-feature with endpoint-halt selector |
| stall_sent | input | 1 | Pulse: STALL handshake returned for an IN or OUT packet |
| pkt_done | input | 1 | Pulse: packet sent or received successfully |
| pkt_len | input | LEN_W | Byte count of the packet flagged by pkt_done |
| max_pkt | input | LEN_W | Maximum packet size of the endpoint |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | 0 = status word, 1 = enable word |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Word selected by cpu_addr |
| irq | output | 1 | Enabled-flag interrupt request |
| out_nak | output | 1 | Ask the protocol engine to NAK OUT packets |

## Verification
Two situations are hard to reach from the ports. One is a zero-length packet whose outcome depends on the size of the previous packet. The other is a hardware flag set that lands in the same cycle as a CPU write-one clear. The random stimulus keeps `max_pkt` small and weights packet lengths toward 0, `max_pkt` and values around it, so zero-length packets often follow both full and short packets. Directed sequences place a set-feature together with a clear-feature, and a packet completion together with a clear of its own flag, in the same cycle.

// File: rtl/ep_stat_pkg.sv
// Package: shared constants of the endpoint status register.
// Assumes a 16-bit CPU data word and four interrupt flags packed from bit 1.
package ep_stat_pkg;
    localparam int REG_W    = 16;
    localparam int NFLAG    = 4;
    localparam int FLAG_LSB = 1;
    localparam int BIT_HALT = 15;
    localparam int BIT_DIR  = 14;
    localparam int BIT_PRES = 13;
    // flag vector indices (register bit = index + FLAG_LSB)
    localparam int FL_HEV = 0;
    localparam int FL_UNH = 1;
    localparam int FL_EOP = 2;
    localparam int FL_EOT = 3;
    localparam logic ADDR_STAT = 1'b0;
    localparam logic ADDR_IEN  = 1'b1;
endpackage

// File: rtl/ep_halt_track.sv
// Module: halt status of one endpoint plus its edge events.
// Assumes request and stall inputs are single-cycle pulses; set has priority.
module ep_halt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic halt,
    output logic ev_halted,
    output logic ev_unhalted
);
    logic halt_q;
    logic halt_d;

    // next halt state: set beats clear
    always_comb begin
        if (set_req)      halt_d = 1'b1;
        else if (clr_req) halt_d = 1'b0;
        else              halt_d = halt_q;
    end

    // halt status register
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= halt_d;
    end

    assign halt        = halt_q;
    assign ev_halted   = !halt_q && halt_d;
    assign ev_unhalted = halt_q && !halt_d;

    AST_HALT_SET:  assert property (@(posedge clk) disable iff (!rst_n) set_req |=> halt_q); // R3
    AST_HALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (halt_q && !clr_req) |=> halt_q); // R4
endmodule

// File: rtl/ep_eot_detect.sv
// Module: end-of-transfer detection from packet byte counts.
// Assumes pkt_done is a pulse with pkt_len valid in the same cycle.
module ep_eot_detect #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] max_pkt,
    output logic             eot_hit
);
    logic last_full_q;
    logic is_full;
    logic is_zero;

    // classify the current packet
    always_comb begin
        is_full = (pkt_len >= max_pkt);
        is_zero = (pkt_len == '0);
        eot_hit = pkt_done && ((!is_full && !is_zero) || (is_zero && last_full_q));
    end

    // remember whether the previous packet was full size
    always_ff @(posedge clk) begin
        if (!rst_n)        last_full_q <= 1'b0;
        else if (pkt_done) last_full_q <= is_full;
    end

    AST_ZLP_AFTER_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !is_zero && !is_full) |=> !last_full_q); // R7
endmodule

// File: rtl/ep_irq_flags.sv
// Module: sticky interrupt flags with write-one-clear, enable word and irq.
// Assumes a hardware set and a clear in one cycle resolve to set.
module ep_irq_flags #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_vec,
    input  logic [NF-1:0] clr_vec,
    input  logic          ien_we,
    input  logic [NF-1:0] ien_wdata,
    output logic [NF-1:0] flags,
    output logic [NF-1:0] ien,
    output logic          irq
);
    logic [NF-1:0] flags_q;
    logic [NF-1:0] ien_q;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        // one sticky flag: set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (set_vec[i]) flags_q[i] <= 1'b1;
            else if (clr_vec[i]) flags_q[i] <= 1'b0;
        end

        AST_FLAG_SET:  assert property (@(posedge clk) disable iff (!rst_n) set_vec[i] |=> flags_q[i]); // R8
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (flags_q[i] && !clr_vec[i]) |=> flags_q[i]); // R8
    end

    // enable word register
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_we) ien_q <= ien_wdata;
    end

    assign flags = flags_q;
    assign ien   = ien_q;
    assign irq   = |(flags_q & ien_q);

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n) (ien_q == '0) |-> !irq); // R9
endmodule

// File: rtl/ep_stat_reg.sv
// Module: status and interrupt register of one USB device endpoint (top).
// Assumes the packet engine, request decoder and CPU bus deliver
// single-cycle pulses; CPU reads are combinational on cpu_addr.
module ep_stat_reg
    import ep_stat_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_present,
    input  logic             cfg_dir_in,
    input  logic             req_set_halt,
    input  logic             req_clr_halt,
    input  logic             stall_sent,
    input  logic             pkt_done,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic             cpu_we,
    input  logic             cpu_addr,
    input  logic [15:0]      cpu_wdata,
    output logic [15:0]      cpu_rdata,
    output logic             irq,
    output logic             out_nak
);
    logic             dir_q;
    logic             pres_q;
    logic             halt;
    logic             ev_halted;
    logic             ev_unhalted;
    logic             eot_hit;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] ien;
    logic [REG_W-1:0] stat_word;
    logic [REG_W-1:0] ien_word;

    // register configuration inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            pres_q <= 1'b0;
        end else begin
            dir_q  <= cfg_dir_in;
            pres_q <= cfg_present;
        end
    end

    ep_halt_track u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (req_set_halt | stall_sent),
        .clr_req     (req_clr_halt),
        .halt        (halt),
        .ev_halted   (ev_halted),
        .ev_unhalted (ev_unhalted)
    );

    ep_eot_detect #(.LEN_W(LEN_W)) u_eot (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_done (pkt_done),
        .pkt_len  (pkt_len),
        .max_pkt  (max_pkt),
        .eot_hit  (eot_hit)
    );

    // gather hardware set events and CPU clear bits
    always_comb begin
        set_vec         = '0;
        set_vec[FL_HEV] = ev_halted;
        set_vec[FL_UNH] = ev_unhalted;
        set_vec[FL_EOP] = pkt_done;
        set_vec[FL_EOT] = eot_hit;
        clr_vec = (cpu_we && cpu_addr == ADDR_STAT) ? cpu_wdata[FLAG_LSB +: NFLAG] : '0;
    end

    ep_irq_flags #(.NF(NFLAG)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .ien_we    (cpu_we && cpu_addr == ADDR_IEN),
        .ien_wdata (cpu_wdata[FLAG_LSB +: NFLAG]),
        .flags     (flags),
        .ien       (ien),
        .irq       (irq)
    );

    // assemble the readable words
    always_comb begin
        stat_word                       = '0;
        stat_word[BIT_HALT]             = halt;
        stat_word[BIT_DIR]              = dir_q;
        stat_word[BIT_PRES]             = pres_q;
        stat_word[FLAG_LSB +: NFLAG]    = flags;
        ien_word                        = '0;
        ien_word[FLAG_LSB +: NFLAG]     = ien;
        cpu_rdata = (cpu_addr == ADDR_IEN) ? ien_word : stat_word;
    end

    assign out_nak = !dir_q && flags[FL_EOT];

    AST_UNHALT_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $fell(halt) |-> flags[FL_UNH]); // R5
    AST_HALT_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) $rose(halt) |-> flags[FL_HEV]); // R5
    AST_EOP_FLAG:    assert property (@(posedge clk) disable iff (!rst_n) pkt_done |=> flags[FL_EOP]); // R6
    AST_EOT_SHORT:   assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_len != '0 && pkt_len < max_pkt) |=> flags[FL_EOT]); // R7
    AST_NAK_OUT:     assert property (@(posedge clk) disable iff (!rst_n) dir_q |-> !out_nak); // R10
endmodule

// File: tb/tb_ep_stat_reg.sv
module tb_ep_stat_reg;
    localparam int LW = 11;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_present = 0, cfg_dir_in = 0, req_set_halt = 0, req_clr_halt = 0;
    logic stall_sent = 0, pkt_done = 0, cpu_we = 0, cpu_addr = 0;
    logic [LW-1:0] pkt_len = '0, max_pkt = 11'd8;
    logic [15:0] cpu_wdata = '0, cpu_rdata;
    logic irq, out_nak;

    int total = 0, bad = 0;
    logic m_halt, m_dir, m_pres, m_last_full;
    logic [3:0] m_flags, m_ien;

    ep_stat_reg #(.LEN_W(LW)) dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_stat();
        return {m_halt, m_dir, m_pres, 8'h00, m_flags, 1'b0};
    endfunction

    function automatic logic [15:0] exp_ien();
        return {11'h000, m_ien, 1'b0};
    endfunction

    // advance one clock: update the model from the driven inputs, then compare
    task automatic tick();
        logic set, nh, eot;
        logic [3:0] sv, cv;
        set = req_set_halt | stall_sent;
        nh  = set ? 1'b1 : (req_clr_halt ? 1'b0 : m_halt);
        eot = pkt_done && ((pkt_len != 0 && pkt_len < max_pkt) || (pkt_len == 0 && m_last_full));
        sv  = {eot, pkt_done, m_halt && !nh, !m_halt && nh};
        cv  = (cpu_we && !cpu_addr) ? cpu_wdata[4:1] : 4'h0;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_halt = 0; m_dir = 0; m_pres = 0; m_last_full = 0; m_flags = 0; m_ien = 0;
        end else begin
            m_flags = sv | (m_flags & ~cv);
            if (cpu_we && cpu_addr) m_ien = cpu_wdata[4:1];
            if (pkt_done) m_last_full = (pkt_len >= max_pkt);
            m_halt = nh;
            m_dir  = cfg_dir_in;
            m_pres = cfg_present;
        end
        if (cpu_addr) chk("R9 enable word", cpu_rdata, exp_ien());
        else          chk("R2 status word", cpu_rdata, exp_stat());
        chk("R9 irq", {15'h0, irq}, {15'h0, |(m_flags & m_ien)});
        chk("R10 out_nak", {15'h0, out_nak}, {15'h0, !m_dir && m_flags[3]});
    endtask

    task automatic idle();
        req_set_halt = 0; req_clr_halt = 0; stall_sent = 0; pkt_done = 0; cpu_we = 0; cpu_wdata = '0;
    endtask

    task automatic pkt(input logic [LW-1:0] len);
        idle(); pkt_done = 1; pkt_len = len; tick(); idle();
    endtask

    task automatic clear_all();
        idle(); cpu_we = 1; cpu_addr = 0; cpu_wdata = 16'hFFFF; tick(); idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        m_halt = 0; m_dir = 0; m_pres = 0; m_last_full = 0; m_flags = 0; m_ien = 0;
        cfg_present = 1; cfg_dir_in = 1;
        repeat (2) tick();
        // R1: reset state seen at both addresses
        chk("R1 status after reset", cpu_rdata, 16'h0000);
        chk("R1 irq after reset", {15'h0, irq}, 16'h0);
        chk("R1 nak after reset", {15'h0, out_nak}, 16'h0);
        cpu_addr = 1; #1;
        chk("R1 enable after reset", cpu_rdata, 16'h0000);
        cpu_addr = 0;
        rst_n = 1;
        tick();
        chk("R2 dir/present follow inputs", cpu_rdata, 16'h6000);

        // R2: writes to read-only bits have no effect
        cpu_we = 1; cpu_wdata = 16'hFFE1; tick(); idle();
        chk("R2 read-only bits", cpu_rdata, 16'h6000);

        // R3: set and clear together -> halted, halt event set
        req_set_halt = 1; req_clr_halt = 1; tick(); idle();
        chk("R3 set wins over clear", cpu_rdata, 16'hE002);
        // R4: stall while halted keeps halt; only clear-feature drops it
        stall_sent = 1; tick(); idle();
        chk("R4 stays halted", cpu_rdata[15:13], 3'b111);
        req_clr_halt = 1; tick(); idle();
        chk("R5 unhalt flag on fall", cpu_rdata, 16'h6006);
        clear_all();
        stall_sent = 1; tick(); idle();
        chk("R3 stall sets halt", cpu_rdata, 16'hE002);
        req_clr_halt = 1; tick(); idle();
        clear_all();

        // R6/R7 on an OUT endpoint with max 8
        cfg_dir_in = 0; max_pkt = 11'd8; tick();
        pkt(11'd8);
        chk("R6 full packet eop only", cpu_rdata, 16'h2008);
        pkt(11'd0);
        chk("R7 zlp after full ends transfer", cpu_rdata, 16'h2018);
        chk("R10 nak while eot pending", {15'h0, out_nak}, 16'h1);
        clear_all();
        pkt(11'd3);
        chk("R7 short packet ends transfer", cpu_rdata, 16'h2018);
        clear_all();
        pkt(11'd0);
        chk("R7 zlp after short no eot", cpu_rdata, 16'h2008);
        chk("R10 no nak without eot", {15'h0, out_nak}, 16'h0);
        clear_all();

        // R8: hardware set and clear in same cycle, and write-zero keeps flag
        pkt(11'd5);
        idle(); cpu_we = 1; cpu_addr = 0; cpu_wdata = 16'h0000; tick(); idle();
        chk("R8 write zero keeps flags", cpu_rdata[4:1], 4'hC);
        pkt_done = 1; pkt_len = 11'd8; cpu_we = 1; cpu_wdata = 16'h0008; tick(); idle();
        chk("R8 set wins over clear", cpu_rdata[4:1], 4'hC);
        cpu_we = 1; cpu_wdata = 16'h0010; tick(); idle();
        chk("R8 clear only selected flag", cpu_rdata[4:1], 4'h4);

        // R9: enable masking
        cpu_we = 1; cpu_addr = 1; cpu_wdata = 16'hFFE7; tick(); idle();
        chk("R9 eop disabled no irq", {15'h0, irq}, 16'h0);
        cpu_we = 1; cpu_wdata = 16'h0008; tick(); idle();
        chk("R9 eop enabled irq", {15'h0, irq}, 16'h1);
        cpu_addr = 0;
        clear_all();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            idle();
            r = $urandom;
            req_set_halt = (r[3:0] == 0);
            req_clr_halt = (r[7:4] == 0);
            stall_sent   = (r[11:8] == 0);
            pkt_done     = r[12];
            case (r[15:13])
                3'd0, 3'd1: pkt_len = '0;
                3'd2, 3'd3: pkt_len = max_pkt;
                3'd4:       pkt_len = max_pkt + 11'd1;
                default:    pkt_len = 11'($urandom_range(0, 9));
            endcase
            cpu_we    = (r[18:16] == 0);
            cpu_addr  = r[19];
            cpu_wdata = 16'($urandom);
            if (r[25:20] == 0) cfg_dir_in = ~cfg_dir_in;
            if (r[31:26] == 0) cfg_present = ~cfg_present;
            if (n % 500 == 0) max_pkt = (max_pkt == 11'd8) ? 11'd4 : 11'd8;
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule